// File: doc/BRIEF.md
# Byte-Aligned Serial-to-Parallel Receiver with Loopback Selection

This block takes one bit per serial clock and turns the stream into bytes. The bit stream comes from the primary line input or from a diagnostic loopback input. An active-low select picks the source. A signal-detect input can force the stream to zero. The bits pass through a serial-in shift register. An upstream framer supplies a bit offset that marks the byte boundary, and a holding register takes a byte at that boundary. An output register then presents the byte on a parallel bus, together with a one-cycle strobe.

The byte clock is modelled as a one-cycle enable in the serial clock domain. A separate enable runs freely at one eighth of the serial rate. An active-low kill input silences both enables. A line-loopback path sends a retimed copy of the primary data back out when it is enabled. This path runs on its own, so it can be active while the diagnostic loopback is selected.

Top module: `bdes_rx`

## Requirements
- R1: While `rst_n` is low, `byte_out`, `byte_stb`, `ref_stb`, `llb_dout` and `llb_oe` are all 0.
- R2: Within each presented byte, bit 7 of `byte_out` holds the earliest serial bit and bit 0 holds the latest.
- R3: Rising edges after reset release are numbered from 0. The holding register takes the eight bits ending at edge e whenever e mod 8 equals the value of `align_off` at that edge. That byte appears on `byte_out` with `byte_stb` high for one cycle, starting at edge e+1. `byte_out` does not change in any other cycle.
- R4: When `loop_sel_n` is 0, the bytes are built from `loop_din`. When it is 1, they are built from `line_din`.
- R5: When `sig_det` is 0 at an edge, the bit entering the shift register at that edge is 0, whichever source is selected.
- R6: `ref_stb` is high for the one cycle after edge e exactly when e mod 8 equals 7 and `kill_n` was 1 at that edge. `align_off` has no effect on it.
- R7: When `kill_n` is 0 at an edge, `ref_stb` and `byte_stb` are 0 after that edge and `byte_out` keeps its value.
- R8: When `llb_en_n` is 0 at an edge, `llb_oe` is 1 after that edge and `llb_dout` equals `line_din` sampled at that edge. When `llb_en_n` is 1, both are 0. `llb_dout` is not affected by `sig_det`.
- R9: Line loopback and diagnostic loopback work at the same time: with both `llb_en_n` and `loop_sel_n` at 0, `llb_dout` carries `line_din` while the bytes come from `loop_din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_din | input | 1 | Primary serial data |
| loop_din | input | 1 | Diagnostic loopback serial data |
| loop_sel_n | input | 1 | 0 selects the loopback data as the source |
| sig_det | input | 1 | Signal present; when 0 the source bit is forced to 0 |
| kill_n | input | 1 | 0 silences both byte-rate enables |
| align_off | input | $clog2(W) | Bit offset of the byte boundary, from the framer |
| llb_en_n | input | 1 | 0 enables the line-loopback output |
| byte_out | output | W | Parallel byte, earliest bit in the MSB |
| byte_stb | output | 1 | One-cycle strobe when a new byte is presented |
| ref_stb | output | 1 | Free-running enable at one eighth of the serial rate |
| llb_dout | output | 1 | Retimed primary data for line loopback |
| llb_oe | output | 1 | Line-loopback output enable |

## Verification
The assertions take for granted that every input is synchronous to `clk` and settles well before each rising edge. They accept `align_off` changing at any edge. Because of that, no assertion claims that byte strobes come exactly eight cycles apart: two hits can fall in adjacent cycles when the offset moves. The stimulus changes all inputs one nanosecond after a rising edge and changes the offset only between phases. The bench's reference model still follows every edge, so an offset change inside a phase would be covered too.

// File: rtl/bdes_pkg.sv
package bdes_pkg;
   // Source selection encoding, driven directly from the active-low select pin.
   typedef enum logic {
      BDES_SRC_LOOP = 1'b0,
      BDES_SRC_LINE = 1'b1
   } bdes_src_e;

   // Widest byte the library accepts.
   localparam int unsigned BDES_MAX_W = 64;
endpackage

// File: rtl/bdes_src.sv
module bdes_src
   import bdes_pkg::*;
#(
   parameter bit LLB_RETIME = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_din,
   input  logic loop_din,
   input  logic loop_sel_n,
   input  logic sig_det,
   input  logic llb_en_n,
   output logic din,
   output logic llb_dout,
   output logic llb_oe
);
   bdes_src_e src;

   assign src = bdes_src_e'(loop_sel_n);

   // Loss of signal blanks whichever stream feeds the shifter.
   always_comb begin
      if (!sig_det)                 din = 1'b0;
      else if (src == BDES_SRC_LINE) din = line_din;
      else                          din = loop_din;
   end

   generate
      if (LLB_RETIME) begin : g_llb_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               llb_dout <= 1'b0;
               llb_oe   <= 1'b0;
            end else begin
               llb_dout <= line_din & ~llb_en_n;
               llb_oe   <= ~llb_en_n;
            end
         end
      end else begin : g_llb_comb
         assign llb_dout = rst_n & line_din & ~llb_en_n;
         assign llb_oe   = rst_n & ~llb_en_n;
         logic unused_clk;
         assign unused_clk = clk;
      end
   endgenerate
endmodule

// File: rtl/bdes_phase.sv
module bdes_phase #(
   parameter int W  = 8,
   localparam int OW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kill_n,
   input  logic [OW-1:0] align_off,
   output logic          hit,
   output logic          ref_stb
);
   logic [OW-1:0] cnt;

   // Free-running bit counter; wraps naturally because W is a power of two.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ref_stb <= 1'b0;
      end else begin
         cnt     <= cnt + OW'(1);
         ref_stb <= kill_n & (cnt == OW'(W - 1));
      end
   end

   // Boundary hit: the bit entering now closes a byte at the framer offset.
   assign hit = (cnt == align_off);
endmodule

// File: rtl/bdes_sipo.sv
module bdes_sipo #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         din,
   input  logic         hit,
   input  logic         kill_n,
   output logic [W-1:0] byte_out,
   output logic         byte_stb
);
   logic [W-1:0] sr;
   logic [W-1:0] sr_nxt;
   logic [W-1:0] hold;
   logic         ld_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_nxt = {sr[W-2:0], din};
      end else begin : g_lsb
         assign sr_nxt = {din, sr[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr       <= '0;
         hold     <= '0;
         ld_q     <= 1'b0;
         byte_out <= '0;
         byte_stb <= 1'b0;
      end else begin
         sr   <= sr_nxt;
         ld_q <= hit;
         if (hit) hold <= sr_nxt;
         if (ld_q && kill_n) byte_out <= hold;
         byte_stb <= ld_q & kill_n;
      end
   end
endmodule

// File: rtl/bdes_rx.sv
module bdes_rx
   import bdes_pkg::*;
#(
   parameter int W          = 8,
   parameter bit MSB_FIRST  = 1'b1,
   parameter bit LLB_RETIME = 1'b1,
   localparam int OW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          line_din,
   input  logic          loop_din,
   input  logic          loop_sel_n,
   input  logic          sig_det,
   input  logic          kill_n,
   input  logic [OW-1:0] align_off,
   input  logic          llb_en_n,
   output logic [W-1:0]  byte_out,
   output logic          byte_stb,
   output logic          ref_stb,
   output logic          llb_dout,
   output logic          llb_oe
);
   generate
      if (W < 2 || W > int'(BDES_MAX_W) || (W & (W - 1)) != 0) begin : g_bad_w
         $error("bdes_rx: W must be a power of two between 2 and BDES_MAX_W");
      end
   endgenerate

   logic din;
   logic hit;

   bdes_src #(.LLB_RETIME(LLB_RETIME)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_din   (line_din),
      .loop_din   (loop_din),
      .loop_sel_n (loop_sel_n),
      .sig_det    (sig_det),
      .llb_en_n   (llb_en_n),
      .din        (din),
      .llb_dout   (llb_dout),
      .llb_oe     (llb_oe)
   );

   bdes_phase #(.W(W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill_n    (kill_n),
      .align_off (align_off),
      .hit       (hit),
      .ref_stb   (ref_stb)
   );

   bdes_sipo #(.W(W), .MSB_FIRST(MSB_FIRST)) u_sipo (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .hit      (hit),
      .kill_n   (kill_n),
      .byte_out (byte_out),
      .byte_stb (byte_stb)
   );
endmodule

// File: rtl/bdes_rx_chk.sv
module bdes_rx_chk #(
   parameter int W  = 8,
   localparam int OW = $clog2(W)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          line_din,
   input logic          kill_n,
   input logic          llb_en_n,
   input logic [W-1:0]  byte_out,
   input logic          byte_stb,
   input logic          ref_stb,
   input logic          llb_dout,
   input logic          llb_oe
);
   // Independent edge counter since reset release, modulo W.
   logic [OW-1:0] g;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g <= '0;
      else        g <= g + OW'(1);
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!ref_stb && !byte_stb && !llb_oe && !llb_dout && byte_out == '0));

   a_r6_ref_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb |-> (g == '0));

   a_r6_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb |=> !ref_stb);

   a_r7_kill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !kill_n |=> (!ref_stb && !byte_stb));

   a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_stb |-> $stable(byte_out));

   a_r8_llb_off: assert property (@(posedge clk) disable iff (!rst_n)
      llb_en_n |=> (!llb_oe && !llb_dout));

   a_r8_llb_copy: assert property (@(posedge clk) disable iff (!rst_n)
      !llb_en_n |=> (llb_oe && llb_dout == $past(line_din)));
endmodule

bind bdes_rx bdes_rx_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .line_din (line_din),
   .kill_n   (kill_n),
   .llb_en_n (llb_en_n),
   .byte_out (byte_out),
   .byte_stb (byte_stb),
   .ref_stb  (ref_stb),
   .llb_dout (llb_dout),
   .llb_oe   (llb_oe)
);

// File: tb/bdes_rx_tb.sv
module bdes_rx_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_din = 1'b0;
   logic       loop_din = 1'b0;
   logic       loop_sel_n = 1'b1;
   logic       sig_det = 1'b1;
   logic       kill_n = 1'b1;
   logic [2:0] align_off = 3'd0;
   logic       llb_en_n = 1'b1;
   logic [7:0] byte_out;
   logic       byte_stb;
   logic       ref_stb;
   logic       llb_dout;
   logic       llb_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // Reference model state.
   int         e = 0;
   logic [7:0] msr = '0;
   logic [7:0] holdm = '0;
   logic [7:0] expout = '0;
   logic       ldm = 1'b0;
   logic [15:0] lf = 16'hACE1;

   always #4 clk = ~clk;

   bdes_rx u_dut (
      .clk(clk), .rst_n(rst_n), .line_din(line_din), .loop_din(loop_din),
      .loop_sel_n(loop_sel_n), .sig_det(sig_det), .kill_n(kill_n),
      .align_off(align_off), .llb_en_n(llb_en_n), .byte_out(byte_out),
      .byte_stb(byte_stb), .ref_stb(ref_stb), .llb_dout(llb_dout), .llb_oe(llb_oe)
   );

   task automatic check(input bit ok, input string what, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s [%s] act=%0h exp=%0h", what, tag, act, exp);
      end
   endtask

   // One serial edge: drive inputs, clock, update model, compare.
   task automatic step(input logic [2:0] off, input bit sel_n, input bit sig,
                       input bit kil, input bit llbn, input bit pat_mode,
                       input logic [7:0] pat, input string tag);
      logic lb, pb, eff, stbx;
      if (pat_mode) lb = pat[7 - (e % 8)];
      else begin
         lb = lf[0];
         lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
      end
      pb = ~lb ^ lf[1];
      line_din = lb; loop_din = pb; loop_sel_n = sel_n; sig_det = sig;
      kill_n = kil; llb_en_n = llbn; align_off = off;
      @(posedge clk);
      #1;
      eff  = sig ? (sel_n ? lb : pb) : 1'b0;
      msr  = {msr[6:0], eff};
      stbx = ldm & kil;
      if (stbx) expout = holdm;
      if ((e % 8) == int'(off)) holdm = msr;
      ldm  = ((e % 8) == int'(off));
      check(ref_stb == (((e % 8) == 7) && kil), "R6 ref_stb", tag, 32'(ref_stb),
            32'(((e % 8) == 7) && kil));
      check(byte_stb == stbx, "R3 byte_stb", tag, 32'(byte_stb), 32'(stbx));
      check(byte_out == expout, "R3 byte_out", tag, 32'(byte_out), 32'(expout));
      check(llb_oe == !llbn, "R8 llb_oe", tag, 32'(llb_oe), 32'(!llbn));
      check(llb_dout == (lb & !llbn), "R8 llb_dout", tag, 32'(llb_dout), 32'(lb & !llbn));
      e++;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(byte_out == 8'h00 && !byte_stb && !ref_stb && !llb_dout && !llb_oe,
            "R1 reset outputs", "reset", {byte_out, byte_stb, ref_stb, llb_dout, llb_oe}, 32'h0);
      rst_n = 1'b1;

      // R3: every boundary offset on random primary data.
      for (int o = 0; o < 8; o++)
         for (int i = 0; i < 48; i++)
            step(3'(o), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R3 offset sweep");

      // R2: a fixed pattern aligned at offset 7 must come out unchanged.
      for (int i = 0; i < 40; i++)
         step(3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC5, "R2 bit order");
      check(byte_out == 8'hC5, "R2 pattern byte", "R2 bit order", 32'(byte_out), 32'hC5);

      // R4: diagnostic loopback source.
      for (int i = 0; i < 64; i++)
         step(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 loop source");

      // R5: loss of signal blanks data; line loopback still follows line_din.
      for (int i = 0; i < 40; i++)
         step(3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R5 no signal");
      check(byte_out == 8'h00, "R5 blank byte", "R5 no signal", 32'(byte_out), 32'h0);

      // Refill with a known byte before killing the enables.
      for (int i = 0; i < 24; i++)
         step(3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h3A, "R3 refill");
      for (int i = 0; i < 40; i++)
         step(3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h96, "R7 kill");
      check(byte_out == 8'h3A, "R7 held byte", "R7 kill", 32'(byte_out), 32'h3A);

      // R6: enables resume on the free-running phase with a new offset.
      for (int i = 0; i < 40; i++)
         step(3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 resume");

      // R8 and R9: line loopback alone, then with diagnostic loopback.
      for (int i = 0; i < 40; i++)
         step(3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R8 line loopback");
      for (int i = 0; i < 48; i++)
         step(3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R9 both loopbacks");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired before completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule